// File: doc/BRIEF.md
# Sound Register Bus Interface

This block connects a CPU bus to the register space of a sound unit. Each CPU access whose address lies below a cartridge boundary is captured into a single pending latch. The latch holds a 5-bit register index, the data byte and a direction flag. The block runs a half-rate tick that toggles on every clock. It releases the pending access as a one-clock strobe on the first clock in which the tick is high. At that point the access goes to one of five sound channels, to the enable path, to the frame-sequencer control, to a sprite-DMA request, or to the side effects of a read.

Accesses at or above the boundary bypass the latch and go straight out on a cartridge port. The same index space also holds two serial controller ports, each loaded in parallel from an 8-bit pad input. The block also holds a status read that combines the channel-active flags, two interrupt flags and one open-bus bit. Read data is returned in the access cycle. Read side effects, such as shifting a controller port or acknowledging the frame interrupt, are applied only at dispatch.

Top module: `snd_regbus`

## Requirements
- R1: An access with address 0x4020 or above asserts `cart_req` in the same cycle, carrying the CPU's address, data and direction. A read of this kind returns `cart_rdata` on `cpu_rdata`. Such an access produces no dispatch strobe.
- R2: An access below 0x4020 is latched. It is dispatched in the first later cycle in which `half_tick` is high, so it appears one cycle after the access when `half_tick` was low in the access cycle, and two cycles after when it was high. Every dispatch strobe is exactly one cycle wide.
- R3: A write to an index from 0 to 19 raises bit index/4 of `ch_wr` (bit 0 first square, 1 second square, 2 triangle, 3 noise, 4 sample channel). `ch_reg` equals index mod 4 and `sb_data` carries the written byte.
- R4: A write to index 20 raises `dma_req` with `dma_addr` equal to the written byte shifted left by 8.
- R5: A read of index 21 returns bit 7 = `dmc_irq`, bit 6 = `frame_irq`, bit 5 = bit 5 of the last bus byte, and bits 4:0 = `chan_active`.
- R6: A read of index 21 raises `frame_irq_ack` for one cycle at its dispatch.
- R7: A write to index 21 raises `en_wr` with the byte on `sb_data`; bits 4:0 are the channel enables.
- R8: A write to index 22 stores bit 0 as the pad strobe. When the stored strobe goes from 1 to 0, both controller shift registers reload from `pad_bits` (port 0 from bits 7:0, port 1 from bits 15:8). Any other write leaves them unchanged.
- R9: A read of index 22 (port 0) or 23 (port 1) returns 0x00 or 0x01 holding bit 0 of that port's shift register. At dispatch, that register shifts right by one and a 1 enters at the top.
- R10: A write to index 23 raises `frm_wr` with the written byte on `sb_data`.
- R11: Indexes 24 to 31 produce no strobe. A read of any index other than 21, 22 or 23 returns the last bus byte, which is updated by every latched write byte and every latched read result.
- R12: After reset no strobe is active and the bus byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access valid for one cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |
| cart_req | output | 1 | Cartridge access valid |
| cart_we | output | 1 | Cartridge direction |
| cart_addr | output | 16 | Cartridge address |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rdata | input | 8 | Cartridge read data |
| chan_active | input | 5 | Channel-active flags for the status read |
| frame_irq | input | 1 | Frame interrupt flag |
| dmc_irq | input | 1 | Sample-channel interrupt flag |
| frame_irq_ack | output | 1 | Clear request for the frame interrupt |
| half_tick | output | 1 | Half-rate tick, high every other cycle |
| ch_wr | output | 5 | One-hot channel write strobe |
| ch_reg | output | 2 | Register within the channel |
| sb_data | output | 8 | Latched byte accompanying every strobe |
| en_wr | output | 1 | Channel-enable write strobe |
| dma_req | output | 1 | Sprite-DMA request strobe |
| dma_addr | output | 16 | Sprite-DMA start address |
| frm_wr | output | 1 | Frame-sequencer control write strobe |
| pad_bits | input | 16 | Parallel pad states, port 1 in the upper byte |

## Verification
The embedded properties check these on every cycle: a pending access survives a low tick unchanged and is gone after a high tick; a cartridge access never creates a pending one; channel strobes are one-hot and one cycle wide; DMA and interrupt acknowledges appear only on a tick; a reload copies the pads; and a shift always brings in a 1. Other behaviours are shown only by the bench's scenarios, with a scoreboard comparing each dispatched strobe in order against its prediction. These are the exact one- or two-cycle dispatch latency, the contents of the status byte, the serial bit order after a reload, the rule that only a 1-to-0 strobe edge reloads, open-bus reads, and the silence of the ignored indexes and of cartridge accesses.

// File: rtl/snd_regbus_pkg.sv
package snd_regbus_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 5;
  localparam int NUM_PADS = 2;

  // index map; the decode depends on these positions
  localparam logic [IDX_W-1:0] IDX_CHAN_LAST = 5'd19;
  localparam logic [IDX_W-1:0] IDX_DMA       = 5'd20;
  localparam logic [IDX_W-1:0] IDX_STAT      = 5'd21;
  localparam logic [IDX_W-1:0] IDX_PAD0      = 5'd22;
  localparam logic [IDX_W-1:0] IDX_PAD1      = 5'd23;

  // status byte bit positions
  localparam int STAT_OB_BIT   = 5;
  localparam int STAT_FRM_BIT  = 6;
  localparam int STAT_DMC_BIT  = 7;

  typedef enum logic [2:0] {
    TGT_CHAN, TGT_DMA, TGT_STAT, TGT_PAD0, TGT_PAD1, TGT_NONE
  } tgt_e;

  typedef struct packed {
    logic              we;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] data;
  } acc_t;

  function automatic tgt_e idx_target(input logic [IDX_W-1:0] idx);
    if (idx <= IDX_CHAN_LAST)  return TGT_CHAN;
    else if (idx == IDX_DMA)   return TGT_DMA;
    else if (idx == IDX_STAT)  return TGT_STAT;
    else if (idx == IDX_PAD0)  return TGT_PAD0;
    else if (idx == IDX_PAD1)  return TGT_PAD1;
    else                       return TGT_NONE;
  endfunction
endpackage

// File: rtl/snd_bus_latch.sv
module snd_bus_latch
  import snd_regbus_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CART_BASE = 16'h4020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              half_tick,
  output logic              pend,
  output acc_t              acc,
  output logic              is_cart,
  output logic              take
);
  logic phase_q, phase_d;
  logic pend_q, pend_d;
  acc_t acc_q, acc_d;

  always_comb begin
    is_cart = (addr >= CART_BASE);
    take    = req && !is_cart;
    phase_d = !phase_q;
    pend_d  = pend_q;
    acc_d   = acc_q;
    if (pend_q && phase_q) pend_d = 1'b0;
    if (take) begin
      pend_d     = 1'b1;
      acc_d.we   = we;
      acc_d.idx  = addr[IDX_W-1:0];
      acc_d.data = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
      acc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
      acc_q   <= acc_d;
    end
  end

  assign half_tick = phase_q;
  assign pend      = pend_q;
  assign acc       = acc_q;

  // R2: a pending access waits through a low tick untouched
  p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !phase_q && !take |=> pend_q && $stable(acc_q));
  // R2: after a high tick the access has been released
  p_pend_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && phase_q && !take |=> !pend_q);
  // R1: cartridge traffic never creates a pending access
  p_cart_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req && is_cart && !pend_q |=> !pend_q);
endmodule

// File: rtl/snd_bus_dispatch.sv
module snd_bus_dispatch
  import snd_regbus_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  acc_t                  acc,
  output logic [NUM_CH-1:0]     ch_wr,
  output logic [1:0]            ch_reg,
  output logic [BYTE_W-1:0]     sb_data,
  output logic                  en_wr,
  output logic                  dma_req,
  output logic [2*BYTE_W-1:0]   dma_addr,
  output logic                  frm_wr,
  output logic                  irq_ack,
  output logic                  pad_wr,
  output logic [NUM_PADS-1:0]   pad_shift
);
  localparam int GRP_W = IDX_W - 2;

  tgt_e tgt;
  logic wr_fire, rd_fire;

  always_comb begin
    tgt     = idx_target(acc.idx);
    wr_fire = fire && acc.we;
    rd_fire = fire && !acc.we;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_wr[c] = wr_fire && (tgt == TGT_CHAN) &&
                      (acc.idx[IDX_W-1:2] == GRP_W'(c));
  end

  assign ch_reg       = acc.idx[1:0];
  assign sb_data      = acc.data;
  assign en_wr        = wr_fire && (tgt == TGT_STAT);
  assign dma_req      = wr_fire && (tgt == TGT_DMA);
  assign dma_addr     = {acc.data, {BYTE_W{1'b0}}};
  assign frm_wr       = wr_fire && (tgt == TGT_PAD1);
  assign irq_ack      = rd_fire && (tgt == TGT_STAT);
  assign pad_wr       = wr_fire && (tgt == TGT_PAD0);
  assign pad_shift[0] = rd_fire && (tgt == TGT_PAD0);
  assign pad_shift[1] = rd_fire && (tgt == TGT_PAD1);

  // R3: at most one channel is addressed per dispatch
  p_ch_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr));
  // R2: a strobe never lasts two cycles
  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_wr) || en_wr || frm_wr |=> !(|ch_wr) && !en_wr && !frm_wr);
endmodule

// File: rtl/snd_pad_serial.sv
module snd_pad_serial
  import snd_regbus_pkg::*;
#(
  parameter int PAD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe_wr,
  input  logic                      strobe_bit,
  input  logic [NUM_PADS-1:0]       shift,
  input  logic [NUM_PADS*PAD_W-1:0] pad_bits,
  output logic [NUM_PADS-1:0]       lsb
);
  logic strobe_q, strobe_d;
  logic reload;

  always_comb begin
    reload   = strobe_wr && strobe_q && !strobe_bit;
    strobe_d = strobe_wr ? strobe_bit : strobe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic [PAD_W-1:0] sr_q, sr_d;

    always_comb begin
      sr_d = sr_q;
      if (reload)        sr_d = pad_bits[p*PAD_W +: PAD_W];
      else if (shift[p]) sr_d = {1'b1, sr_q[PAD_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
    end

    assign lsb[p] = sr_q[0];

    // R8: a falling strobe copies the pad state
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> sr_q == $past(pad_bits[p*PAD_W +: PAD_W]));
    // R9: shifting fills from the top with a 1
    p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shift[p] && !reload |=> sr_q[PAD_W-1]);
  end
endmodule

// File: rtl/snd_regbus.sv
module snd_regbus
  import snd_regbus_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CART_BASE = 16'h4020,
  parameter int                NUM_CH    = 5,
  parameter int                PAD_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [BYTE_W-1:0]         cpu_wdata,
  output logic [BYTE_W-1:0]         cpu_rdata,
  output logic                      cart_req,
  output logic                      cart_we,
  output logic [ADDR_W-1:0]         cart_addr,
  output logic [BYTE_W-1:0]         cart_wdata,
  input  logic [BYTE_W-1:0]         cart_rdata,
  input  logic [NUM_CH-1:0]         chan_active,
  input  logic                      frame_irq,
  input  logic                      dmc_irq,
  output logic                      frame_irq_ack,
  output logic                      half_tick,
  output logic [NUM_CH-1:0]         ch_wr,
  output logic [1:0]                ch_reg,
  output logic [BYTE_W-1:0]         sb_data,
  output logic                      en_wr,
  output logic                      dma_req,
  output logic [2*BYTE_W-1:0]       dma_addr,
  output logic                      frm_wr,
  input  logic [NUM_PADS*PAD_W-1:0] pad_bits
);
  logic [1:0]           rs_q;
  logic                 rst_s_n;
  logic                 pend, is_cart, take, pad_wr;
  acc_t                 acc;
  logic [NUM_PADS-1:0]  pad_shift, pad_lsb;
  logic [BYTE_W-1:0]    bus_q, bus_d, stat_byte;
  tgt_e                 rd_tgt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  snd_bus_latch #(.ADDR_W(ADDR_W), .CART_BASE(CART_BASE)) u_latch (
    .clk(clk), .rst_n(rst_s_n), .req(cpu_req), .we(cpu_we),
    .addr(cpu_addr), .wdata(cpu_wdata), .half_tick(half_tick),
    .pend(pend), .acc(acc), .is_cart(is_cart), .take(take)
  );

  snd_bus_dispatch #(.NUM_CH(NUM_CH)) u_disp (
    .clk(clk), .rst_n(rst_s_n), .fire(pend && half_tick), .acc(acc),
    .ch_wr(ch_wr), .ch_reg(ch_reg), .sb_data(sb_data), .en_wr(en_wr),
    .dma_req(dma_req), .dma_addr(dma_addr), .frm_wr(frm_wr),
    .irq_ack(frame_irq_ack), .pad_wr(pad_wr), .pad_shift(pad_shift)
  );

  snd_pad_serial #(.PAD_W(PAD_W)) u_pad (
    .clk(clk), .rst_n(rst_s_n), .strobe_wr(pad_wr),
    .strobe_bit(sb_data[0]), .shift(pad_shift),
    .pad_bits(pad_bits), .lsb(pad_lsb)
  );

  always_comb begin
    stat_byte                  = '0;
    stat_byte[NUM_CH-1:0]      = chan_active;
    stat_byte[STAT_OB_BIT]     = bus_q[STAT_OB_BIT];
    stat_byte[STAT_FRM_BIT]    = frame_irq;
    stat_byte[STAT_DMC_BIT]    = dmc_irq;
    rd_tgt                     = idx_target(cpu_addr[IDX_W-1:0]);
    if (is_cart) cpu_rdata = cart_rdata;
    else begin
      case (rd_tgt)
        TGT_STAT: cpu_rdata = stat_byte;
        TGT_PAD0: cpu_rdata = {{(BYTE_W-1){1'b0}}, pad_lsb[0]};
        TGT_PAD1: cpu_rdata = {{(BYTE_W-1){1'b0}}, pad_lsb[1]};
        default:  cpu_rdata = bus_q;
      endcase
    end
    bus_d = bus_q;
    if (take) bus_d = cpu_we ? cpu_wdata : cpu_rdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) bus_q <= '0;
    else          bus_q <= bus_d;
  end

  assign cart_req   = cpu_req && is_cart;
  assign cart_we    = cpu_we;
  assign cart_addr  = cpu_addr;
  assign cart_wdata = cpu_wdata;

  // R6: the interrupt acknowledge only appears on a half-rate tick
  p_ack_tick_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_irq_ack |-> half_tick && !frm_wr);
  // R4: a DMA request is a dispatch on a tick and targets no channel
  p_dma_tick_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    dma_req |-> half_tick && !(|ch_wr) && !en_wr);
endmodule

// File: tb/sim_snd_regbus.sv
`timescale 1ns/1ps
module sim_snd_regbus;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic        cart_req, cart_we;
  logic [15:0] cart_addr;
  logic [7:0]  cart_wdata;
  logic [7:0]  cart_rdata = 8'h5A;
  logic [4:0]  chan_active = '0;
  logic        frame_irq = 1'b0, dmc_irq = 1'b0;
  logic        frame_irq_ack, half_tick;
  logic [4:0]  ch_wr;
  logic [1:0]  ch_reg;
  logic [7:0]  sb_data;
  logic        en_wr, dma_req, frm_wr;
  logic [15:0] dma_addr;
  logic [15:0] pad_bits = '0;

  int nchecks = 0;
  int nerrors = 0;
  bit mon_on  = 1'b0;
  bit done    = 1'b0;
  logic [19:0] exp_q[$];

  always #2 clk = ~clk;

  snd_regbus u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
    .cart_wdata(cart_wdata), .cart_rdata(cart_rdata),
    .chan_active(chan_active), .frame_irq(frame_irq), .dmc_irq(dmc_irq),
    .frame_irq_ack(frame_irq_ack), .half_tick(half_tick), .ch_wr(ch_wr),
    .ch_reg(ch_reg), .sb_data(sb_data), .en_wr(en_wr), .dma_req(dma_req),
    .dma_addr(dma_addr), .frm_wr(frm_wr), .pad_bits(pad_bits)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected dispatch item: {kind, value}; kinds 0..4 channel, 5 enable,
  // 6 dma, 7 frame control, 8 interrupt acknowledge
  task automatic predict(input logic [15:0] a, input bit w, input logic [7:0] d);
    logic [4:0] idx = a[4:0];
    if (a >= 16'h4020) return;
    if (w) begin
      if (idx <= 5'd19)      exp_q.push_back({1'b0, idx[4:2], 6'd0, idx[1:0], d});
      else if (idx == 5'd20) exp_q.push_back({4'd6, d, 8'h00});
      else if (idx == 5'd21) exp_q.push_back({4'd5, 8'h00, d});
      else if (idx == 5'd23) exp_q.push_back({4'd7, 8'h00, d});
    end else if (idx == 5'd21) begin
      exp_q.push_back({4'd8, 16'h0000});
    end
  endtask

  task automatic access(input logic [15:0] a, input bit w, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    predict(a, w, d);
    cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    #1 rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] unused_rd;
    access(a, 1'b1, d, unused_rd);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
    logic [7:0] got;
    access(a, 1'b0, 8'h00, got);
    check(got === exp, req, got, exp);
  endtask

  // R2: latency from access cycle to strobe, depending on the tick phase
  task automatic latency(input bit phase, input int exp_delay);
    int k = 0;
    do @(negedge clk); while (half_tick !== phase);
    predict(16'h4002, 1'b1, 8'h3E);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h4002; cpu_wdata = 8'h3E;
    do begin
      @(negedge clk);
      cpu_req = 1'b0;
      k++;
    end while (ch_wr === 5'b0 && k < 5);
    check(k == exp_delay, "R2 dispatch latency", k, exp_delay);
    @(negedge clk);
    check(ch_wr === 5'b0, "R2 strobe width", ch_wr, 0);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      logic [19:0] obs;
      bit any;
      any = 1'b0;
      obs = '0;
      for (int c = 0; c < 5; c++)
        if (ch_wr[c]) begin any = 1'b1; obs = {4'(c), 6'd0, ch_reg, sb_data}; end
      if (en_wr)         begin any = 1'b1; obs = {4'd5, 8'h00, sb_data}; end
      if (dma_req)       begin any = 1'b1; obs = {4'd6, dma_addr}; end
      if (frm_wr)        begin any = 1'b1; obs = {4'd7, 8'h00, sb_data}; end
      if (frame_irq_ack) begin any = 1'b1; obs = {4'd8, 16'h0000}; end
      if (any) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected strobe", obs, 0);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check(obs === e, "R3/R4/R6/R7/R10 dispatched item", obs, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerrors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12: quiet after reset
    check({ch_wr, en_wr, dma_req, frm_wr, frame_irq_ack} === 9'b0,
          "R12 strobes idle", {ch_wr, en_wr, dma_req, frm_wr, frame_irq_ack}, 0);
    mon_on = 1'b1;
    rd_chk(16'h4019, 8'h00, "R12 bus byte after reset");

    // R2: latency both phases
    latency(1'b0, 1);
    latency(1'b1, 2);

    // R3: channel writes
    wr(16'h4000, 8'h11);
    wr(16'h4005, 8'h22);
    wr(16'h400A, 8'h33);
    wr(16'h400F, 8'h44);
    wr(16'h4013, 8'h55);
    // R4: sprite DMA
    wr(16'h4014, 8'h02);
    wr(16'h4014, 8'hFF);
    // R7: enable write
    wr(16'h4015, 8'h1F);
    // R10: frame control
    wr(16'h4017, 8'hC0);

    // R11: ignored indexes, open bus
    wr(16'h4001, 8'hC3);
    rd_chk(16'h4019, 8'hC3, "R11 open-bus read");
    wr(16'h401A, 8'h77);
    rd_chk(16'h4003, 8'h77, "R11 ignored write updates bus only");

    // R5 and R6: status reads
    wr(16'h4000, 8'h20);
    chan_active = 5'b10101; frame_irq = 1'b1; dmc_irq = 1'b0;
    rd_chk(16'h4015, 8'h75, "R5 status byte");
    chan_active = 5'b01010; frame_irq = 1'b0; dmc_irq = 1'b1;
    rd_chk(16'h4015, 8'hAA, "R5 status byte with open-bus bit");

    // R8/R9: controller ports
    pad_bits = 16'h3CA5;
    wr(16'h4016, 8'h01);
    wr(16'h4016, 8'h00);
    pad_bits = 16'h0000;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] pad0 = 8'hA5;
      rd_chk(16'h4016, {7'b0, pad0[i]}, "R9 port 0 serial bit");
    end
    rd_chk(16'h4016, 8'h01, "R9 port 0 fill with one");
    rd_chk(16'h4017, 8'h00, "R9 port 1 bit 0");
    rd_chk(16'h4017, 8'h00, "R9 port 1 bit 1");
    wr(16'h4016, 8'h00);
    rd_chk(16'h4017, 8'h01, "R8 no reload without falling strobe");
    wr(16'h4016, 8'h01);
    wr(16'h4016, 8'h00);
    rd_chk(16'h4016, 8'h00, "R8 reload on falling strobe");

    // R1: cartridge pass-through
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h4020; cpu_wdata = 8'h99;
    #1;
    check(cart_req && cart_we && cart_addr == 16'h4020 && cart_wdata == 8'h99,
          "R1 cartridge write", {cart_req, cart_we, cart_addr, cart_wdata},
          {2'b11, 16'h4020, 8'h99});
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk(16'h8000, 8'h5A, "R1 cartridge read");
    rd_chk(16'h401F, 8'h00, "R11 bus byte untouched by cartridge");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all accesses dispatched", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule